// File: doc/BRIEF.md
# Guarded Byte-Wide Nonvolatile Memory Controller

This block sits between a CPU register bus and a small byte-wide nonvolatile data array. The CPU sees four byte registers: control, data, address low and address high. Through them it starts a read or one of three programming operations: erase only, write only, or erase followed by write as one operation. Programming is guarded. A master arming bit must be set first, and the start bit must follow within a short window. A start bit that arrives outside the window does nothing.

A started program operation holds a busy flag for a duration set by a parameter. While the flag is set, the controller refuses all other requests, and the mode field and the address registers keep their values. The controller drives a CPU stall request for a fixed number of cycles after each accepted read or programming start. A ready interrupt output, gated by an enable bit, is high whenever no operation is running.

The storage array is a behavioural model. It has one synchronous read port and one write port. It starts fully erased (every byte 0xFF). A plain write combines the new byte with the old one by bitwise AND.

Top module: `nvm_ctrl`

## Requirements
- R1: Register select codes are 0 = control, 1 = data, 2 = address low, 3 = address high. A read of a register returns it on bus_rdata one clock after the select is sampled. The control register reads as {2'b00, mode[1:0], irq_enable, armed, busy, 1'b0}. The read-start bit is bit 0, the program-start bit is bit 1, the arming bit is bit 2, the interrupt enable is bit 3 and the mode field is bits 5:4. After reset every register, cpu_stall and ready_irq are 0.
- R2: Writing 1 to the arming bit sets `armed`. A control write with the program-start bit is accepted only if it lands 1 to 4 clocks after the arming write. A start at any later clock is ignored, and so is a start that arrives in the same write as the arming bit. `armed` clears by itself 4 clocks after it is set, or when a program operation starts.
- R3: After an accepted start, busy reads 1 for exactly ERASE_CYC (default 6) clocks in erase-only mode, WRITE_CYC (default 4) clocks in write-only mode, or their sum (10) in erase-then-write mode. It then clears by itself.
- R4: While busy is set, read starts, program starts and arming writes are all refused.
- R5: A control write with the read-start bit loads the byte at the current address into the data register and raises cpu_stall for 4 clocks.
- R6: An accepted program start raises cpu_stall for 2 clocks.
- R7: ready_irq equals irq_enable AND NOT busy.
- R8: Mode encoding is 2'b00 = erase then write, 2'b01 = erase only, 2'b10 = write only, and 2'b11 = reserved. A start in the reserved mode is ignored. An erase leaves 0xFF, a write-only leaves old AND new, and erase-then-write leaves the new byte. The mode used is the one carried in the start write.
- R9: While busy is set, writes to the mode field, address low and address high are ignored.
- R10: The array address is {address_high[AW-9:0], address_low}. Locations that differ only in the high byte are distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data of the selected register |
| cpu_stall | output | 1 | CPU stall request |
| ready_irq | output | 1 | Ready interrupt request |

## Verification
The hardest condition to reach is a program start that arrives at the exact edge of the arming window. The bench places it by counting idle clocks between the arming write and the start write: three idle clocks must give a start, and four must not. The refusals that depend on busy are also difficult, because each one needs a write to land while an operation is running. The bench starts a short write-only operation and issues address, mode, read and arming writes in the clocks directly after it. It then reads the registers back and checks the stall count after busy clears.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    MODE_BOTH  = 2'b00,
    MODE_ERASE = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_RSVD  = 2'b11
  } nvm_mode_e;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_ALO  = 2'd2;
  localparam logic [1:0] SEL_AHI  = 2'd3;

  localparam int B_READ = 0;
  localparam int B_PROG = 1;
  localparam int B_ARM  = 2;
  localparam int B_IEN  = 3;
  localparam int B_MODE = 4;

  // Byte left in the cell at the end of a program operation
  function automatic logic [7:0] merge_byte(input nvm_mode_e m,
                                            input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    case (m)
      MODE_ERASE: return 8'hFF;
      MODE_WRITE: return old_b & new_b;
      default:    return new_b;
    endcase
  endfunction
endpackage

// File: rtl/nvm_arm_timer.sv
module nvm_arm_timer #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  input  logic consume,
  output logic armed
);
  localparam int CW = $clog2(WINDOW + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (consume)       cnt <= '0;
    else if (arm_set)       cnt <= CW'(WINDOW);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign armed = (cnt != '0);

  AST_ARM_DROPS_ON_START: assert property (@(posedge clk) disable iff (rst)
    consume |=> !armed); // R2
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
    (arm_set && !consume) |=> armed); // R2
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int READ_STALL = 4,
  parameter int PROG_STALL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_read,
  input  logic start_prog,
  output logic stall
);
  localparam int MAXS = (READ_STALL > PROG_STALL) ? READ_STALL : PROG_STALL;
  localparam int SW   = $clog2(MAXS + 1);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start_read)    cnt <= SW'(READ_STALL);
    else if (start_prog)    cnt <= SW'(PROG_STALL);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign stall = (cnt != '0);

  AST_READ_STALLS: assert property (@(posedge clk) disable iff (rst)
    start_read |=> stall); // R5
  AST_PROG_STALLS: assert property (@(posedge clk) disable iff (rst)
    start_prog |=> stall); // R6
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_pkg::*;
#(
  parameter int ERASE_CYC = 6,
  parameter int WRITE_CYC = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  nvm_mode_e start_mode,
  output logic      busy,
  output logic      done,
  output nvm_mode_e op_mode
);
  localparam int BOTH_CYC = ERASE_CYC + WRITE_CYC;
  localparam int CW       = $clog2(BOTH_CYC + 1);
  logic [CW-1:0] cnt, load_val;

  always_comb begin
    case (start_mode)
      MODE_ERASE: load_val = CW'(ERASE_CYC);
      MODE_WRITE: load_val = CW'(WRITE_CYC);
      default:    load_val = CW'(BOTH_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      op_mode <= MODE_BOTH;
    end else if (start && cnt == '0) begin
      cnt     <= load_val;
      op_mode <= start_mode;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R3
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R4
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we)    mem[addr] <= din;
    if (rd_en) dout <= mem[addr];
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int AW         = 9,
  parameter int ERASE_CYC  = 6,
  parameter int WRITE_CYC  = 4,
  parameter int ARM_WINDOW = 4,
  parameter int READ_STALL = 4,
  parameter int PROG_STALL = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_stall,
  output logic       ready_irq
);
  localparam int HW = AW - 8;

  logic [7:0]    addr_lo, data_q, op_data, arr_dout, arr_din, rd_mux;
  logic [HW-1:0] addr_hi;
  logic [AW-1:0] arr_addr;
  nvm_mode_e     mode_q, wr_mode, op_mode;
  logic          ien_q, rd_pend, busy, armed, done;
  logic          ctl_we, start_read, start_prog, arm_set;

  assign ctl_we     = bus_we && (bus_sel == SEL_CTL);
  assign wr_mode    = nvm_mode_e'(bus_wdata[B_MODE +: 2]);
  assign start_prog = ctl_we && bus_wdata[B_PROG] && armed && !busy
                      && (wr_mode != MODE_RSVD);
  assign start_read = ctl_we && bus_wdata[B_READ] && !busy && !start_prog;
  assign arm_set    = ctl_we && bus_wdata[B_ARM] && !busy && !start_prog;
  assign arr_addr   = {addr_hi, addr_lo};
  assign arr_din    = merge_byte(op_mode, arr_dout, op_data);
  assign ready_irq  = ien_q && !busy;

  nvm_arm_timer #(.WINDOW(ARM_WINDOW)) u_arm (
    .clk(clk), .rst(rst), .arm_set(arm_set), .consume(start_prog), .armed(armed)
  );

  nvm_prog_seq #(.ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start_prog), .start_mode(wr_mode),
    .busy(busy), .done(done), .op_mode(op_mode)
  );

  nvm_stall_gen #(.READ_STALL(READ_STALL), .PROG_STALL(PROG_STALL)) u_stall (
    .clk(clk), .rst(rst), .start_read(start_read), .start_prog(start_prog),
    .stall(cpu_stall)
  );

  nvm_array #(.AW(AW)) u_array (
    .clk(clk), .rd_en(start_read || start_prog), .we(done),
    .addr(arr_addr), .din(arr_din), .dout(arr_dout)
  );

  always_comb begin
    case (bus_sel)
      SEL_CTL:  rd_mux = {2'b00, mode_q, ien_q, armed, busy, 1'b0};
      SEL_DATA: rd_mux = data_q;
      SEL_ALO:  rd_mux = addr_lo;
      default:  rd_mux = {{(8-HW){1'b0}}, addr_hi};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo   <= '0;
      addr_hi   <= '0;
      data_q    <= '0;
      op_data   <= '0;
      mode_q    <= MODE_BOTH;
      ien_q     <= 1'b0;
      rd_pend   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      rd_pend   <= start_read;
      bus_rdata <= rd_mux;
      if (bus_we && !busy) begin
        if (bus_sel == SEL_ALO) addr_lo <= bus_wdata;
        if (bus_sel == SEL_AHI) addr_hi <= bus_wdata[HW-1:0];
      end
      if (ctl_we) begin
        ien_q <= bus_wdata[B_IEN];
        if (!busy) mode_q <= wr_mode;
      end
      if (rd_pend)                              data_q <= arr_dout;
      else if (bus_we && bus_sel == SEL_DATA)   data_q <= bus_wdata;
      if (start_prog) op_data <= data_q;
    end
  end

  AST_BUSY_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed)); // R2
  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(arr_addr)); // R9
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q)); // R9
  AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_pend || $past(!busy)); // R4
endmodule

// File: tb/nvm_ctrl_tb.sv
module nvm_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_stall, ready_irq;

  int checks = 0;
  int fails  = 0;
  int stall_total = 0;

  always #2 clk = ~clk;

  nvm_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_stall(cpu_stall), .ready_irq(ready_irq)
  );

  always @(negedge clk) if (cpu_stall) stall_total++;

  // vector: mode[34:33], addr[32:24], data[23:16], expected[15:8], busy clocks[7:0]
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {2'b00, 9'h012, 8'hA5, 8'hA5, 8'd10},
    {2'b10, 9'h012, 8'h3C, 8'h24, 8'd4},
    {2'b01, 9'h012, 8'h00, 8'hFF, 8'd6},
    {2'b10, 9'h012, 8'h5A, 8'h5A, 8'd4},
    {2'b00, 9'h112, 8'h0F, 8'h0F, 8'd10},
    {2'b10, 9'h1FF, 8'h77, 8'h77, 8'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] m, input logic ien,
                                     input logic arm, input logic prog,
                                     input logic rd);
    return {2'b00, m, ien, arm, prog, rd};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    bus_sel = sel; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] v);
    bus_sel = sel; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    wr(2'd2, a[7:0]);
    wr(2'd3, {7'd0, a[8]});
  endtask

  task automatic poll_busy(output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      rd(2'd0, v);
      if (!v[1]) break;
      n++;
    end
  endtask

  task automatic read_byte(input logic [8:0] a, output logic [7:0] v);
    set_addr(a);
    wr(2'd0, ctl(2'b00, 1'b1, 1'b0, 1'b0, 1'b1));
    repeat (6) @(negedge clk);
    rd(2'd1, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    checks++; fails++;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset stall", cpu_stall, 0);
    chk("R1 reset irq", ready_irq, 0);

    // Table-driven program sequences
    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      m = VEC[i][34:33];
      set_addr(VEC[i][32:24]);
      wr(2'd1, VEC[i][23:16]);
      wr(2'd0, ctl(m, 1'b1, 1'b1, 1'b0, 1'b0));
      s0 = stall_total;
      wr(2'd0, ctl(m, 1'b1, 1'b0, 1'b1, 1'b0));
      chk("R7 irq low while busy", ready_irq, 0);
      poll_busy(n);
      chk("R3 busy duration", n, VEC[i][7:0]);
      chk("R6 program stall clocks", stall_total - s0, 2);
      chk("R7 irq high when idle", ready_irq, 1);
      s0 = stall_total;
      read_byte(VEC[i][32:24], v);
      chk("R5 read stall clocks", stall_total - s0, 4);
      chk("R8 array contents", v, VEC[i][15:8]);
    end

    // R10 high byte separates locations: 0x012 still holds 0x5A
    read_byte(9'h012, v);
    chk("R10 distinct high byte", v, 8'h5A);

    // R2 start three idle clocks after arming: accepted
    set_addr(9'h020);
    wr(2'd1, 8'h11);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b1, 1'b0));
    poll_busy(n);
    chk("R2 start at window edge accepted", n, 4);

    // R2 start four idle clocks after arming: ignored; armed readback
    wr(2'd0, ctl(2'b10, 1'b1, 1'b1, 1'b0, 1'b0));
    rd(2'd0, v);
    chk("R2 armed reads one", v[2], 1);
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    chk("R2 armed self-clears", v[2], 0);
    wr(2'd1, 8'h00);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b1, 1'b0));
    poll_busy(n);
    chk("R2 late start ignored", n, 0);
    read_byte(9'h020, v);
    chk("R2 late start leaves data", v, 8'h11);

    // R2 arm and start in the same write: ignored
    set_addr(9'h021);
    wr(2'd1, 8'h00);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b1, 1'b1, 1'b0));
    poll_busy(n);
    chk("R2 same-write start ignored", n, 0);

    // R8 reserved mode start ignored
    wr(2'd0, ctl(2'b11, 1'b1, 1'b1, 1'b0, 1'b0));
    wr(2'd0, ctl(2'b11, 1'b1, 1'b0, 1'b1, 1'b0));
    poll_busy(n);
    chk("R8 reserved mode ignored", n, 0);
    read_byte(9'h021, v);
    chk("R8 reserved leaves byte erased", v, 8'hFF);

    // R4 / R9 refusals while busy
    set_addr(9'h030);
    wr(2'd1, 8'h42);
    wr(2'd0, ctl(2'b10, 1'b1, 1'b1, 1'b0, 1'b0));
    s0 = stall_total;
    wr(2'd0, ctl(2'b10, 1'b1, 1'b0, 1'b1, 1'b0));
    wr(2'd2, 8'h55);
    wr(2'd0, ctl(2'b01, 1'b1, 1'b0, 1'b0, 1'b1));
    wr(2'd0, ctl(2'b01, 1'b1, 1'b1, 1'b0, 1'b0));
    poll_busy(n);
    rd(2'd0, v);
    chk("R9 mode locked", v[5:4], 2'b10);
    chk("R4 arming refused while busy", v[2], 0);
    chk("R4 read refused while busy", stall_total - s0, 2);
    rd(2'd2, v);
    chk("R9 address low locked", v, 8'h30);
    read_byte(9'h030, v);
    chk("R4 busy write result", v, 8'h42);

    // R7 irq disabled
    wr(2'd0, ctl(2'b00, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    chk("R7 irq gated off", ready_irq, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule